// File: doc/BRIEF.md
# Password Retry Limiter with Lockout

This block sits beside a password comparator in a secured storage controller. It counts failed password attempts, and the count persists from one transaction to the next. When the count runs past its tolerance, the block locks. While the lock is held, every read and write password comparison is forced to fail. On entering the lock, the block requests a single erase of all memory arrays. The stored passwords are left untouched. The lock is released only by a reset-device command that carried the correct reset password.

The comparator reports each result as a one-cycle pulse on one of four inputs:
- a correct read or write password,
- an incorrect password of any kind or target,
- a reset-device command accepted with the valid reset password,
- a reset-password command accepted with the valid reset password.

The reset-password command asks for both an array erase and a return of every password to zero. The erase engine and the password store are outside this block. They act on the two one-cycle request outputs. All outputs are registered, so every response appears one clock after the pulse that caused it.

Top module: `pwg_top`

## Requirements
- R1: After reset, the lock output is low, both clear requests are low, and the failure count is zero.
- R2: While unlocked, each miss pulse adds one to the failure count. MAX_TRIES (default 8) misses in a row leave the block unlocked. The next miss after that sets the lock output on the following clock edge.
- R3: While unlocked, a match pulse returns the failure count to zero. After it, a further MAX_TRIES misses are tolerated again.
- R4: The clock edge that sets the lock also raises the array-clear request for exactly one cycle. The password-clear request stays low on that edge.
- R5: While locked, miss and match pulses have no effect. The lock output stays high and no clear request is raised.
- R6: A reset-device pulse clears the failure count and the lock on the next edge. It raises no clear request. This holds both before and after lockout.
- R7: A reset-password pulse raises the array-clear and password-clear requests together for one cycle, on the next edge. It leaves the lock state and the failure count unchanged.
- R8: When pulses coincide in one cycle, reset-device overrides match and miss, and match overrides miss. A reset-password pulse acts alongside any of them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pw_match_i | input | 1 | One-cycle pulse: correct read or write password |
| pw_miss_i | input | 1 | One-cycle pulse: incorrect password of any kind |
| rst_dev_ok_i | input | 1 | One-cycle pulse: reset-device command with valid reset password |
| rst_pw_ok_i | input | 1 | One-cycle pulse: reset-password command with valid reset password |
| locked_o | output | 1 | Level: forces read/write password comparisons to fail |
| clr_arrays_o | output | 1 | One-cycle request to erase all memory arrays |
| clr_pwds_o | output | 1 | One-cycle request to set all passwords to zero |

## Verification
Directed runs of exactly MAX_TRIES misses, then one more, separate a lockout threshold that is off by one from a correct one. A run of misses interrupted by a match shows whether the match truly clears the count or only pauses it. Pulses are then applied while locked, and coincident pulses are applied, to expose wrong precedence and lock leakage. A long seeded random mix of all four pulses, compared every cycle against a bench model, covers orderings the directed cases miss.

// File: rtl/pwg_pkg.sv
package pwg_pkg;
  typedef struct packed {
    logic rst_dev;
    logic rst_pw;
    logic match;
    logic miss;
  } pwg_evt_t;

  function automatic int pwg_cnt_w(input int tries);
    return $clog2(tries + 1);
  endfunction
endpackage

// File: rtl/pwg_tally.sv
module pwg_tally #(
  parameter int MAX_TRIES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic match_i,
  input  logic miss_i,
  input  logic rst_dev_i,
  output logic locked_o,
  output logic trip_o
);
  localparam int CW = pwg_pkg::pwg_cnt_w(MAX_TRIES);
  localparam logic [CW-1:0] LIMIT = CW'(MAX_TRIES);

  logic [CW-1:0] cnt_q;
  logic          locked_q;

  // a miss beyond the tolerated count, with nothing of higher precedence
  assign trip_o = miss_i & ~match_i & ~rst_dev_i & ~locked_q & (cnt_q == LIMIT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      locked_q <= 1'b0;
    end else if (rst_dev_i) begin
      cnt_q    <= '0;
      locked_q <= 1'b0;
    end else if (!locked_q) begin
      if (match_i)
        cnt_q <= '0;
      else if (miss_i) begin
        if (cnt_q == LIMIT) locked_q <= 1'b1;
        else                cnt_q    <= cnt_q + 1'b1;
      end
    end
  end

  assign locked_o = locked_q;

  p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LIMIT);
  p_lock_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    locked_q && !rst_dev_i |=> locked_q && $stable(cnt_q));
  p_unlock_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rst_dev_i |=> !locked_q && cnt_q == '0);
  p_lock_at_limit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked_q) |-> $past(cnt_q) == LIMIT);
  p_match_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    match_i && !locked_q |=> cnt_q == '0);
endmodule

// File: rtl/pwg_clear_req.sv
module pwg_clear_req (
  input  logic clk,
  input  logic rst_n,
  input  logic trip_i,
  input  logic rst_pw_i,
  output logic clr_arrays_o,
  output logic clr_pwds_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      clr_arrays_o <= 1'b0;
      clr_pwds_o   <= 1'b0;
    end else begin
      clr_arrays_o <= trip_i | rst_pw_i;
      clr_pwds_o   <= rst_pw_i;
    end
  end

  p_pwds_with_arrays_r7: assert property (@(posedge clk) disable iff (!rst_n)
    clr_pwds_o |-> clr_arrays_o);
  p_pwds_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    clr_pwds_o |-> $past(rst_pw_i));
endmodule

// File: rtl/pwg_top.sv
module pwg_top #(
  parameter int MAX_TRIES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pw_match_i,
  input  logic pw_miss_i,
  input  logic rst_dev_ok_i,
  input  logic rst_pw_ok_i,
  output logic locked_o,
  output logic clr_arrays_o,
  output logic clr_pwds_o
);
  pwg_pkg::pwg_evt_t evt;
  logic trip;

  assign evt = '{rst_dev: rst_dev_ok_i, rst_pw: rst_pw_ok_i,
                 match: pw_match_i, miss: pw_miss_i};

  pwg_tally #(.MAX_TRIES(MAX_TRIES)) u_tally (
    .clk      (clk),
    .rst_n    (rst_n),
    .match_i  (evt.match),
    .miss_i   (evt.miss),
    .rst_dev_i(evt.rst_dev),
    .locked_o (locked_o),
    .trip_o   (trip)
  );

  pwg_clear_req u_req (
    .clk         (clk),
    .rst_n       (rst_n),
    .trip_i      (trip),
    .rst_pw_i    (evt.rst_pw),
    .clr_arrays_o(clr_arrays_o),
    .clr_pwds_o  (clr_pwds_o)
  );

  p_lock_erases_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked_o) |-> clr_arrays_o);
  p_no_pwd_clear_on_trip_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked_o) && !$past(rst_pw_ok_i) |-> !clr_pwds_o);
  p_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rst_dev_ok_i && !rst_pw_ok_i |=> !clr_arrays_o && !locked_o);
endmodule

// File: tb/tb_pwg_top.sv
`timescale 1ns/1ps
module tb_pwg_top;
  localparam int MAX_TRIES = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m = 1'b0, x = 1'b0, d = 1'b0, p = 1'b0;
  logic locked, clr_a, clr_p;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  int  e_cnt = 0;
  bit  e_lock = 1'b0;
  bit  e_ca = 1'b0;
  bit  e_cp = 1'b0;

  always #10 clk = ~clk;

  pwg_top #(.MAX_TRIES(MAX_TRIES)) dut (
    .clk(clk), .rst_n(rst_n), .pw_match_i(m), .pw_miss_i(x),
    .rst_dev_ok_i(d), .rst_pw_ok_i(p),
    .locked_o(locked), .clr_arrays_o(clr_a), .clr_pwds_o(clr_p)
  );

  task automatic check(input string tag, input string what, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0b expected=%0b at %0t", tag, what, act, exp, $time);
    end
  endtask

  // bench model of the requirements
  function automatic string model(input bit mm, input bit xx, input bit dd, input bit pp);
    string tag;
    bit trip;
    trip = 1'b0;
    tag = "R2";
    if (dd) begin
      e_cnt = 0; e_lock = 1'b0; tag = (mm || xx) ? "R8" : "R6";
    end else if (e_lock) begin
      if (mm || xx) tag = "R5";
    end else if (mm) begin
      e_cnt = 0; tag = xx ? "R8" : "R3";
    end else if (xx) begin
      if (e_cnt == MAX_TRIES) begin e_lock = 1'b1; trip = 1'b1; tag = "R4"; end
      else e_cnt++;
    end
    e_ca = trip | pp;
    e_cp = pp;
    if (pp) tag = "R7";
    return tag;
  endfunction

  task automatic step(input bit mm, input bit xx, input bit dd, input bit pp);
    string tag;
    m = mm; x = xx; d = dd; p = pp;
    @(posedge clk);
    #5;
    m = 1'b0; x = 1'b0; d = 1'b0; p = 1'b0;
    tag = model(mm, xx, dd, pp);
    check(tag, "locked", locked, e_lock);
    check(tag, "clr_arrays", clr_a, e_ca);
    check(tag, "clr_pwds", clr_p, e_cp);
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    int seed;
    seed = 1234;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1", "locked", locked, 1'b0);
    check("R1", "clr_arrays", clr_a, 1'b0);
    check("R1", "clr_pwds", clr_p, 1'b0);

    // R2: exactly MAX_TRIES misses tolerated, next one locks (R4)
    for (int i = 0; i < MAX_TRIES; i++) step(0, 1, 0, 0);
    step(0, 1, 0, 0);
    step(0, 0, 0, 0);                 // R4 pulse is one cycle
    // R5: locked ignores miss and match
    step(0, 1, 0, 0);
    step(1, 0, 0, 0);
    // R7 while locked: lock stays
    step(0, 0, 0, 1);
    step(0, 0, 0, 0);
    // R6 unlock
    step(0, 0, 1, 0);
    // R3: match mid-run restarts tolerance
    for (int i = 0; i < MAX_TRIES; i++) step(0, 1, 0, 0);
    step(1, 0, 0, 0);
    for (int i = 0; i < MAX_TRIES; i++) step(0, 1, 0, 0);
    // R8: match beats miss, reset-device beats miss
    step(1, 1, 0, 0);
    for (int i = 0; i < MAX_TRIES; i++) step(0, 1, 0, 0);
    step(0, 1, 1, 0);
    step(0, 1, 0, 0);
    // R6 before overflow, R7 does not touch count
    step(0, 0, 1, 0);
    for (int i = 0; i < MAX_TRIES; i++) step(0, 1, 0, 0);
    step(0, 0, 0, 1);
    step(0, 1, 0, 0);                 // R7 count was kept: this locks
    step(0, 0, 1, 0);

    // constrained random mix
    for (int i = 0; i < 3000; i++) begin
      int r;
      bit mm, xx, dd, pp;
      r  = int'($urandom_range(0, 99));
      xx = (r < 55);
      mm = (r >= 55 && r < 62) || (r == 99);
      dd = ($urandom_range(0, 99) < 3);
      pp = ($urandom_range(0, 99) < 3);
      step(mm, xx, dd, pp);
    end
    finish_run();
  end
endmodule